// File: doc/BRIEF.md
# Instruction Sequence Lock Controller

This block sits beside an instruction pipeline and follows a short run of instructions that comes after a lock-prefix instruction. When a prefix retires, the block loads a down-counter with the number of instructions the prefix covers, from one to four. While that counter is non-zero it raises an interrupt-lock qualifier. The interrupt logic uses that qualifier to hold off ordinary interrupts, peripheral event transfers and low-priority traps. Extended-type prefixes also select an alternate addressing mode for the same run. The block reports that mode to the address logic as a flag and a mode code.

There is only one counter. A prefix that retires inside a running sequence replaces both the count and the mode; nothing is stacked. A high-priority trap entry ends the sequence at once. The lock and the extended mode are gone before the trap handler's first instruction. Any instructions of the sequence still left after the handler returns run unlocked. Address computation, interrupt arbitration and trap vectoring live elsewhere.

None of the pins carries a data stream. All of them are plain control and status signals, so none of them has a handshake or back-pressure.

Top module: `seq_lock_ctrl`

## Requirements
- R1: After reset, `irq_lock_o`=0, `ext_addr_o`=0, `ext_mode_o`=0 and `remain_o`=0.
- R2: When `prefix_i` is high in a cycle, `remain_o` becomes `prefix_len_i`+1 after the next rising edge. `irq_lock_o` is high from that edge on, so the lock covers the very next instruction.
- R3: Each cycle with `retire_i` high, `prefix_i` low, `trap_i` low and a non-zero count lowers `remain_o` by one. A `retire_i` in the same cycle as `prefix_i` is the prefix itself and is not counted. `irq_lock_o` falls when the count reaches 0.
- R4: Cycles with `retire_i` low leave the count unchanged. This covers multi-cycle instructions and wait states, so such an instruction consumes exactly one count.
- R5: Mode codes on `prefix_mode_i` are 0 = lock only, 1 = extended page and 2 = extended segment. During a sequence, `ext_mode_o` shows the code. `ext_addr_o` is high for codes 1 and 2 and low for code 0.
- R6: Mode code 3 is treated as lock only. It gives `ext_mode_o`=0 and `ext_addr_o`=0, while the lock still applies.
- R7: A prefix that retires while a sequence is running reloads the count with its own length and replaces the mode.
- R8: `trap_i` clears the count after the next edge. From that edge, `irq_lock_o`, `ext_addr_o` and `ext_mode_o` are all 0. Later retires do not bring the sequence back.
- R9: When `trap_i` and `prefix_i` are high in the same cycle, the trap wins and the count becomes 0.
- R10: Whenever `remain_o` is 0, `ext_mode_o` reads 0 and `ext_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| prefix_i | input | 1 | A lock prefix retired this cycle |
| prefix_len_i | input | LEN_W | Length operand n; the sequence covers n+1 instructions |
| prefix_mode_i | input | 2 | Mode code of the prefix |
| trap_i | input | 1 | High-priority trap entry |
| irq_lock_o | output | 1 | Mask for ordinary interrupts, event transfers and low-priority traps |
| ext_addr_o | output | 1 | Extended addressing is in force |
| ext_mode_o | output | 2 | Active mode code |
| remain_o | output | CNT_W | Instructions left in the sequence |

## Verification
The bench builds the block with the default 2-bit length operand. With that setting the count goes from 1 to 4, so random stimulus easily reaches every length and every mode code, including the reserved code 3. Short sequences also make nested prefixes common. Random stimulus often lands traps in the middle of a sequence and sometimes in the same cycle as a prefix. Directed cases pin down the no-count rule for the prefix's own retire, long stalls, and the reserved mode.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SLC_LOCK_ONLY = 2'd0,
    SLC_EXT_PAGE  = 2'd1,
    SLC_EXT_SEG   = 2'd2,
    SLC_RESERVED  = 2'd3
  } slc_mode_e;

  // Map a raw mode code to the mode that is actually held.
  function automatic slc_mode_e slc_sanitize(input logic [MODE_W-1:0] raw);
    case (raw)
      2'd1:    return SLC_EXT_PAGE;
      2'd2:    return SLC_EXT_SEG;
      default: return SLC_LOCK_ONLY;
    endcase
  endfunction
endpackage

// File: rtl/slc_len_counter.sv
module slc_len_counter #(
  parameter  int LEN_W = 2,
  localparam int CNT_W = $clog2((1 << LEN_W) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             trap_i,
  input  logic             retire_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign zero_o   = (cnt_q == '0);
  assign step     = retire_i && !load_i && !trap_i && !zero_o;
  assign expire_o = step && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (trap_i)      cnt_d = '0;
    else if (load_i) cnt_d = CNT_W'(len_i) + CNT_W'(1);
    else if (step)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8
  trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (cnt_q == '0));
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !trap_i) |=> (cnt_q == CNT_W'($past(len_i)) + CNT_W'(1)));
  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !load_i && !trap_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !load_i && !trap_i) |=> $stable(cnt_q));
  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(1 << LEN_W));
endmodule

// File: rtl/slc_mode_hold.sv
module slc_mode_hold
  import slc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              trap_i,
  input  logic              expire_i,
  output slc_mode_e         mode_o
);
  slc_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (trap_i)        mode_d = SLC_LOCK_ONLY;
    else if (load_i)   mode_d = slc_sanitize(mode_i);
    else if (expire_i) mode_d = SLC_LOCK_ONLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SLC_LOCK_ONLY;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R6
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != SLC_RESERVED);
  // R7
  mode_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !trap_i && mode_i == 2'd2) |=> (mode_q == SLC_EXT_SEG));
endmodule

// File: rtl/slc_qual_out.sv
module slc_qual_out
  import slc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_i,
  input  slc_mode_e         mode_i,
  output logic              lock_o,
  output logic              ext_o,
  output logic [MODE_W-1:0] mode_o
);
  assign lock_o = !zero_i;
  assign mode_o = zero_i ? MODE_W'(SLC_LOCK_ONLY) : MODE_W'(mode_i);
  assign ext_o  = !zero_i && (mode_i != SLC_LOCK_ONLY);

  // R5
  ext_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_o |-> lock_o);
  // R10
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (mode_o == '0 && !ext_o));
endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import slc_pkg::*;
#(
  parameter  int LEN_W = 2,
  localparam int CNT_W = $clog2((1 << LEN_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              prefix_i,
  input  logic [LEN_W-1:0]  prefix_len_i,
  input  logic [MODE_W-1:0] prefix_mode_i,
  input  logic              trap_i,
  output logic              irq_lock_o,
  output logic              ext_addr_o,
  output logic [MODE_W-1:0] ext_mode_o,
  output logic [CNT_W-1:0]  remain_o
);
  logic      zero_w, expire_w;
  slc_mode_e mode_w;

  slc_len_counter #(.LEN_W(LEN_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (prefix_i),
    .len_i    (prefix_len_i),
    .trap_i   (trap_i),
    .retire_i (retire_i),
    .cnt_o    (remain_o),
    .zero_o   (zero_w),
    .expire_o (expire_w)
  );

  slc_mode_hold mode_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (prefix_i),
    .mode_i   (prefix_mode_i),
    .trap_i   (trap_i),
    .expire_i (expire_w),
    .mode_o   (mode_w)
  );

  slc_qual_out qual_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .zero_i (zero_w),
    .mode_i (mode_w),
    .lock_o (irq_lock_o),
    .ext_o  (ext_addr_o),
    .mode_o (ext_mode_o)
  );

  // R9
  trap_beats_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && prefix_i) |=> (!irq_lock_o && !ext_addr_o));
endmodule

// File: tb/seq_lock_ctrl_tb_top.sv
module seq_lock_ctrl_tb_top;
  localparam int LEN_W = 2;
  localparam int CNT_W = $clog2((1 << LEN_W) + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 1'b0, prefix_i = 1'b0, trap_i = 1'b0;
  logic [LEN_W-1:0] prefix_len_i = '0;
  logic [1:0] prefix_mode_i = '0;
  logic irq_lock_o, ext_addr_o;
  logic [1:0] ext_mode_o;
  logic [CNT_W-1:0] remain_o;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int exp_mode = 0;

  always #10 clk = ~clk;

  seq_lock_ctrl #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .prefix_i(prefix_i),
    .prefix_len_i(prefix_len_i), .prefix_mode_i(prefix_mode_i), .trap_i(trap_i),
    .irq_lock_o(irq_lock_o), .ext_addr_o(ext_addr_o), .ext_mode_o(ext_mode_o),
    .remain_o(remain_o)
  );

  function automatic int held_mode(input int m);
    return (m == 1 || m == 2) ? m : 0;
  endfunction

  function automatic int exp_out_mode(input int c, input int m);
    return (c != 0) ? m : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, int'(remain_o), exp_cnt, "remain");
    chk(tag, int'(irq_lock_o), (exp_cnt != 0) ? 1 : 0, "lock");
    chk(tag, int'(ext_mode_o), exp_out_mode(exp_cnt, exp_mode), "mode");
    chk(tag, int'(ext_addr_o), (exp_cnt != 0 && exp_mode != 0) ? 1 : 0, "ext");
  endtask

  // Drive one cycle at the falling edge, step the model, then check at the next falling edge.
  task automatic cycle(input logic ret, input logic pre, input int len, input int mode,
                       input logic trp, input string tag);
    retire_i = ret; prefix_i = pre; prefix_len_i = LEN_W'(len);
    prefix_mode_i = 2'(mode); trap_i = trp;
    if (trp) begin
      exp_cnt = 0; exp_mode = 0;
    end else if (pre) begin
      exp_cnt = len + 1; exp_mode = held_mode(mode);
    end else if (ret && exp_cnt != 0) begin
      exp_cnt--;
      if (exp_cnt == 0) exp_mode = 0;
    end
    @(negedge clk);
    retire_i = 1'b0; prefix_i = 1'b0; trap_i = 1'b0;
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2, R3: prefix with its own retire, len 2 -> 3 instructions
    cycle(1, 1, 2, 0, 0, "R2");
    cycle(1, 0, 0, 0, 0, "R3");
    // R4: stalls hold the count
    repeat (5) cycle(0, 0, 0, 0, 0, "R4");
    cycle(1, 0, 0, 0, 0, "R3");
    cycle(1, 0, 0, 0, 0, "R3");
    cycle(1, 0, 0, 0, 0, "R10");
    // R5: page mode, then segment mode
    cycle(0, 1, 3, 1, 0, "R5");
    cycle(1, 0, 0, 0, 0, "R5");
    // R7: nested reload to segment with length 1
    cycle(1, 1, 0, 2, 0, "R7");
    cycle(1, 0, 0, 0, 0, "R10");
    // R6: reserved mode is lock only
    cycle(0, 1, 1, 3, 0, "R6");
    cycle(1, 0, 0, 0, 0, "R6");
    // R8: trap mid-sequence, no resume
    cycle(1, 0, 0, 0, 1, "R8");
    cycle(1, 0, 0, 0, 0, "R8");
    // R9: trap with prefix
    cycle(0, 1, 3, 2, 1, "R9");
    // R3: full length 4
    cycle(0, 1, 3, 1, 0, "R2");
    repeat (4) cycle(1, 0, 0, 0, 0, "R3");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, p, t;
      string tag;
      r = ($urandom % 2) == 0;
      p = ($urandom % 5) == 0;
      t = ($urandom % 16) == 0;
      if (t && p)       tag = "R9";
      else if (t)       tag = "R8";
      else if (p)       tag = (exp_cnt != 0) ? "R7" : "R2";
      else if (r)       tag = "R3";
      else              tag = "R4";
      cycle(r, p, int'($urandom % 4), int'($urandom % 4), t, tag);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule